// File: doc/BRIEF.md
# Paired-Page Associative Translation Lookup

This block is a fully associative address translation buffer. Each of its entries describes one naturally aligned pair of virtual pages and holds two physical frame addresses, one for the lower (even) page of the pair and one for the upper (odd) page. The page size of an entry is variable. A per-entry page mask widens the pair beyond its minimum size of two 4 KB pages. An entry belongs either to one address-space identifier (ASID) or to all of them, when its global bit is set.

A lookup presents a virtual address, the current ASID and a write flag. One cycle later the block returns a result code, the translated physical address and read/write permission bits. When the lookup does not yield a usable translation, it also returns the values that the fault-side registers take: the faulting address, an updated context word and an updated entry-high word. A separate write port loads a complete entry at a chosen index. Entry storage and the lookup path are the whole block. The replacement policy is the concern of the caller.

Result codes are 0 MATCH, 1 BADADDR, 2 NOMATCH, 3 INVALID and 4 DIRTY, carried on 3 bits.

Top module: `ptlb_pair_lookup`

## Requirements
- R1: While reset is low, every entry field and every result output is cleared. After reset, a read lookup of address 0 with ASID 0 therefore hits entry 0 with a clear valid bit and returns INVALID (code 3).
- R2: `res_valid` is high exactly in the cycle after a cycle with `lk_valid` high. The result outputs hold their values while no lookup is presented.
- R3: An entry hits when its global bit is set or its stored ASID equals `lk_asid`, and its VPN equals the virtual address once the bits under the effective mask are cleared in both. The effective mask is the entry's page mask ORed with 2^(PAGE_SHIFT+1)-1, which is 0x1FFF by default.
- R4: The odd half (index 1 of `wr_valid`, `wr_dirty` and the odd frame) is selected when the address bit at the highest set position of the effective mask is 1. Otherwise the even half (index 0) is selected. On MATCH, `res_paddr` is the selected frame address ORed with the address bits under the effective mask shifted right by one.
- R5: A hit whose selected half has its valid bit clear returns INVALID (code 3).
- R6: A read hit to a valid half, or a write hit to a valid half whose dirty bit is set, returns MATCH (code 0). On MATCH, `res_perm` bit 0 (read) is 1 and bit 1 (write) equals the selected dirty bit. For any other code, `res_perm` and `res_paddr` are zero.
- R7: A write lookup that hits a valid half whose dirty bit is clear returns DIRTY (code 4).
- R8: A lookup with no hitting entry returns NOMATCH (code 2). Code 1 (BADADDR) is never produced.
- R9: When several entries hit, the entry with the lowest index supplies the translation.
- R10: `res_fault` is 1 exactly when the code is not MATCH. On a fault, `flt_badvaddr` is the address, `flt_context` is `cur_context` with bits 22:0 replaced by (address >> 9) AND 0x7FFFF0, and `flt_entryhi` is the address with bits 12:0 cleared, ORed with `lk_asid` in bits 7:0. Without a fault, all three are zero.
- R11: A write with `wr_en` high updates the entry at `wr_idx` at the clock edge. A lookup presented in the same cycle sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load an entry this cycle |
| wr_idx | input | IDX_W | Entry index to load |
| wr_vpn | input | VA_W | Virtual pair base, in address form |
| wr_mask | input | VA_W | Page mask, in address form |
| wr_asid | input | ASID_W | Owning address-space identifier |
| wr_global | input | 1 | Entry matches any ASID |
| wr_pfn_even | input | PA_W | Physical frame of the even page, in address form |
| wr_pfn_odd | input | PA_W | Physical frame of the odd page, in address form |
| wr_valid | input | 2 | Valid bits, bit 0 even, bit 1 odd |
| wr_dirty | input | 2 | Dirty (writable) bits, bit 0 even, bit 1 odd |
| lk_valid | input | 1 | Present a lookup this cycle |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_asid | input | ASID_W | Current address-space identifier |
| lk_write | input | 1 | Lookup is for a store |
| cur_context | input | VA_W | Present context word, upper bits preserved on fault |
| res_valid | output | 1 | Result available |
| res_code | output | 3 | Result code |
| res_paddr | output | PA_W | Translated physical address |
| res_perm | output | 2 | Bit 0 read, bit 1 write |
| res_fault | output | 1 | Lookup produced a fault |
| flt_badvaddr | output | VA_W | Faulting address |
| flt_context | output | VA_W | Updated context word |
| flt_entryhi | output | VA_W | Updated entry-high word |

## Verification
The bench builds the block with NUM_ENTRIES = 8 and keeps the 32-bit address widths, the 8-bit ASID and 4 KB base pages. With eight entries, the bench can load overlapping entries at low and high indices and check that the lowest index wins. It also loads a 64 KB page entry, so the odd-half select bit moves from bit 12 to bit 16. The lookups span every result code, ASID and global matching, a write and a lookup in the same cycle, and back-to-back lookups, whose results a queue checks in order.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;

   typedef enum logic [2:0] {
      RC_MATCH   = 3'd0,
      RC_BADADDR = 3'd1,
      RC_NOMATCH = 3'd2,
      RC_INVALID = 3'd3,
      RC_DIRTY   = 3'd4
   } res_code_e;

   localparam int unsigned PERM_RD = 0;
   localparam int unsigned PERM_WR = 1;

   localparam int unsigned CTX_FIELD_LSB_SHIFT = 9;
   localparam int unsigned CTX_KEEP_FROM       = 23;

endpackage

// File: rtl/ptlb_entry_cmp.sv
module ptlb_entry_cmp #(
   parameter int unsigned VA_W       = 32,
   parameter int unsigned ASID_W     = 8,
   parameter int unsigned PAGE_SHIFT = 12
) (
   input  logic [VA_W-1:0]   ent_vpn,
   input  logic [VA_W-1:0]   ent_mask,
   input  logic [ASID_W-1:0] ent_asid,
   input  logic              ent_global,
   input  logic [VA_W-1:0]   va,
   input  logic [ASID_W-1:0] cur_asid,
   output logic              hit,
   output logic              odd_half,
   output logic [VA_W-1:0]   off_mask
);
   localparam logic [VA_W-1:0] MIN_MASK = (VA_W'(1) << (PAGE_SHIFT + 1)) - VA_W'(1);

   logic [VA_W-1:0] eff_mask;
   logic [VA_W-1:0] half_bit;
   logic            owner_ok;
   logic            tag_ok;

   always_comb begin
      eff_mask = ent_mask | MIN_MASK;
      half_bit = eff_mask & ~(eff_mask >> 1);
      owner_ok = ent_global || (ent_asid == cur_asid);
      tag_ok   = (va & ~eff_mask) == (ent_vpn & ~eff_mask);
      hit      = owner_ok && tag_ok;
      odd_half = |(va & half_bit);
      off_mask = eff_mask >> 1;
   end

endmodule

// File: rtl/ptlb_first_hit.sv
module ptlb_first_hit #(
   parameter int unsigned NUM = 16
) (
   input  logic [NUM-1:0] hits,
   output logic [NUM-1:0] grant,
   output logic           any_hit
);
   logic [NUM:0] seen;

   assign seen[0] = 1'b0;

   for (genvar i = 0; i < NUM; i++) begin : g_chain
      assign grant[i]  = hits[i] & ~seen[i];
      assign seen[i+1] = seen[i] | hits[i];
   end

   assign any_hit = seen[NUM];

endmodule

// File: rtl/ptlb_resolve.sv
module ptlb_resolve
   import ptlb_pkg::*;
#(
   parameter int unsigned VA_W       = 32,
   parameter int unsigned PA_W       = 32,
   parameter int unsigned ASID_W     = 8,
   parameter int unsigned PAGE_SHIFT = 12
) (
   input  logic              any_hit,
   input  logic              odd_half,
   input  logic [VA_W-1:0]   off_mask,
   input  logic [1:0]        sel_valid,
   input  logic [1:0]        sel_dirty,
   input  logic [PA_W-1:0]   sel_pfn_even,
   input  logic [PA_W-1:0]   sel_pfn_odd,
   input  logic [VA_W-1:0]   va,
   input  logic [ASID_W-1:0] cur_asid,
   input  logic              is_write,
   input  logic [VA_W-1:0]   cur_context,
   output res_code_e         code,
   output logic [PA_W-1:0]   paddr,
   output logic [1:0]        perm,
   output logic              fault,
   output logic [VA_W-1:0]   badvaddr,
   output logic [VA_W-1:0]   context_o,
   output logic [VA_W-1:0]   entryhi_o
);
   localparam logic [VA_W-1:0] PAIR_MASK = (VA_W'(1) << (PAGE_SHIFT + 1)) - VA_W'(1);
   localparam logic [VA_W-1:0] CTX_LOW   = (VA_W'(1) << CTX_KEEP_FROM) - VA_W'(1);
   localparam logic [VA_W-1:0] CTX_TAKE  = CTX_LOW & ~VA_W'(15);

   logic            half_valid;
   logic            half_dirty;
   logic [PA_W-1:0] half_pfn;

   always_comb begin
      half_valid = odd_half ? sel_valid[1] : sel_valid[0];
      half_dirty = odd_half ? sel_dirty[1] : sel_dirty[0];
      half_pfn   = odd_half ? sel_pfn_odd  : sel_pfn_even;

      if (!any_hit)                     code = RC_NOMATCH;
      else if (!half_valid)             code = RC_INVALID;
      else if (is_write && !half_dirty) code = RC_DIRTY;
      else                              code = RC_MATCH;

      paddr = '0;
      perm  = '0;
      if (code == RC_MATCH) begin
         paddr          = half_pfn | PA_W'(va & off_mask);
         perm[PERM_RD]  = 1'b1;
         perm[PERM_WR]  = half_dirty;
      end

      fault     = (code != RC_MATCH);
      badvaddr  = '0;
      context_o = '0;
      entryhi_o = '0;
      if (fault) begin
         badvaddr  = va;
         context_o = (cur_context & ~CTX_LOW) | ((va >> CTX_FIELD_LSB_SHIFT) & CTX_TAKE);
         entryhi_o = (va & ~PAIR_MASK) | VA_W'(cur_asid);
      end
   end

endmodule

// File: rtl/ptlb_pair_lookup.sv
module ptlb_pair_lookup
   import ptlb_pkg::*;
#(
   parameter int unsigned NUM_ENTRIES = 16,
   parameter int unsigned VA_W        = 32,
   parameter int unsigned PA_W        = 32,
   parameter int unsigned ASID_W      = 8,
   parameter int unsigned PAGE_SHIFT  = 12,
   localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [VA_W-1:0]   wr_vpn,
   input  logic [VA_W-1:0]   wr_mask,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic              wr_global,
   input  logic [PA_W-1:0]   wr_pfn_even,
   input  logic [PA_W-1:0]   wr_pfn_odd,
   input  logic [1:0]        wr_valid,
   input  logic [1:0]        wr_dirty,
   input  logic              lk_valid,
   input  logic [VA_W-1:0]   lk_vaddr,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic              lk_write,
   input  logic [VA_W-1:0]   cur_context,
   output logic              res_valid,
   output logic [2:0]        res_code,
   output logic [PA_W-1:0]   res_paddr,
   output logic [1:0]        res_perm,
   output logic              res_fault,
   output logic [VA_W-1:0]   flt_badvaddr,
   output logic [VA_W-1:0]   flt_context,
   output logic [VA_W-1:0]   flt_entryhi
);

   // elaboration-time parameter checks
   if (NUM_ENTRIES < 2) begin : g_bad_entries
      $error("NUM_ENTRIES must be at least 2");
   end
   if (VA_W < CTX_KEEP_FROM + 1) begin : g_bad_va
      $error("VA_W must leave room for the context field");
   end
   if (PAGE_SHIFT + 1 >= VA_W) begin : g_bad_page
      $error("PAGE_SHIFT too large for VA_W");
   end
   if (ASID_W > PAGE_SHIFT + 1) begin : g_bad_asid
      $error("ASID_W must fit below the pair offset");
   end

   // entry storage
   logic [VA_W-1:0]   e_vpn    [NUM_ENTRIES];
   logic [VA_W-1:0]   e_mask   [NUM_ENTRIES];
   logic [ASID_W-1:0] e_asid   [NUM_ENTRIES];
   logic              e_global [NUM_ENTRIES];
   logic [PA_W-1:0]   e_pfn0   [NUM_ENTRIES];
   logic [PA_W-1:0]   e_pfn1   [NUM_ENTRIES];
   logic [1:0]        e_valid  [NUM_ENTRIES];
   logic [1:0]        e_dirty  [NUM_ENTRIES];

   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_store
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            e_vpn[i]    <= '0;
            e_mask[i]   <= '0;
            e_asid[i]   <= '0;
            e_global[i] <= 1'b0;
            e_pfn0[i]   <= '0;
            e_pfn1[i]   <= '0;
            e_valid[i]  <= '0;
            e_dirty[i]  <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(i))) begin
            e_vpn[i]    <= wr_vpn;
            e_mask[i]   <= wr_mask;
            e_asid[i]   <= wr_asid;
            e_global[i] <= wr_global;
            e_pfn0[i]   <= wr_pfn_even;
            e_pfn1[i]   <= wr_pfn_odd;
            e_valid[i]  <= wr_valid;
            e_dirty[i]  <= wr_dirty;
         end
      end
   end

   // parallel compare
   logic [NUM_ENTRIES-1:0] hits;
   logic [NUM_ENTRIES-1:0] odd_vec;
   logic [VA_W-1:0]        offm   [NUM_ENTRIES];

   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
      ptlb_entry_cmp #(
         .VA_W       (VA_W),
         .ASID_W     (ASID_W),
         .PAGE_SHIFT (PAGE_SHIFT)
      ) u_cmp (
         .ent_vpn    (e_vpn[i]),
         .ent_mask   (e_mask[i]),
         .ent_asid   (e_asid[i]),
         .ent_global (e_global[i]),
         .va         (lk_vaddr),
         .cur_asid   (lk_asid),
         .hit        (hits[i]),
         .odd_half   (odd_vec[i]),
         .off_mask   (offm[i])
      );
   end

   // lowest-index priority
   logic [NUM_ENTRIES-1:0] grant;
   logic                   any_hit;

   ptlb_first_hit #(.NUM(NUM_ENTRIES)) u_prio (
      .hits    (hits),
      .grant   (grant),
      .any_hit (any_hit)
   );

   // one-hot AND-OR select of the winning entry
   logic              s_odd;
   logic [VA_W-1:0]   s_offm;
   logic [1:0]        s_valid;
   logic [1:0]        s_dirty;
   logic [PA_W-1:0]   s_pfn0;
   logic [PA_W-1:0]   s_pfn1;

   always_comb begin
      s_odd   = 1'b0;
      s_offm  = '0;
      s_valid = '0;
      s_dirty = '0;
      s_pfn0  = '0;
      s_pfn1  = '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
         s_odd   = s_odd   | (grant[i] & odd_vec[i]);
         s_offm  = s_offm  | ({VA_W{grant[i]}} & offm[i]);
         s_valid = s_valid | ({2{grant[i]}} & e_valid[i]);
         s_dirty = s_dirty | ({2{grant[i]}} & e_dirty[i]);
         s_pfn0  = s_pfn0  | ({PA_W{grant[i]}} & e_pfn0[i]);
         s_pfn1  = s_pfn1  | ({PA_W{grant[i]}} & e_pfn1[i]);
      end
   end

   res_code_e         n_code;
   logic [PA_W-1:0]   n_paddr;
   logic [1:0]        n_perm;
   logic              n_fault;
   logic [VA_W-1:0]   n_badv;
   logic [VA_W-1:0]   n_ctx;
   logic [VA_W-1:0]   n_ehi;

   ptlb_resolve #(
      .VA_W       (VA_W),
      .PA_W       (PA_W),
      .ASID_W     (ASID_W),
      .PAGE_SHIFT (PAGE_SHIFT)
   ) u_resolve (
      .any_hit      (any_hit),
      .odd_half     (s_odd),
      .off_mask     (s_offm),
      .sel_valid    (s_valid),
      .sel_dirty    (s_dirty),
      .sel_pfn_even (s_pfn0),
      .sel_pfn_odd  (s_pfn1),
      .va           (lk_vaddr),
      .cur_asid     (lk_asid),
      .is_write     (lk_write),
      .cur_context  (cur_context),
      .code         (n_code),
      .paddr        (n_paddr),
      .perm         (n_perm),
      .fault        (n_fault),
      .badvaddr     (n_badv),
      .context_o    (n_ctx),
      .entryhi_o    (n_ehi)
   );

   // result register
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid    <= 1'b0;
         res_code     <= '0;
         res_paddr    <= '0;
         res_perm     <= '0;
         res_fault    <= 1'b0;
         flt_badvaddr <= '0;
         flt_context  <= '0;
         flt_entryhi  <= '0;
      end else begin
         res_valid <= lk_valid;
         if (lk_valid) begin
            res_code     <= n_code;
            res_paddr    <= n_paddr;
            res_perm     <= n_perm;
            res_fault    <= n_fault;
            flt_badvaddr <= n_badv;
            flt_context  <= n_ctx;
            flt_entryhi  <= n_ehi;
         end
      end
   end

   // assertions
   AST_RES_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> res_valid); // R2
   AST_RES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !res_valid); // R2
   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && (any_hit == (hits != '0))); // R9
   AST_MATCH_READ_PERM: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_code == RC_MATCH) |-> res_perm[PERM_RD]); // R6
   AST_WRITE_MATCH_WRPERM: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_code == RC_MATCH && $past(lk_write)) |-> res_perm[PERM_WR]); // R6
   AST_FAULT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_fault == (res_code != RC_MATCH))); // R10
   AST_NO_BADADDR: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_code != RC_BADADDR)); // R8
   AST_FAULT_BADV: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_fault) |-> (flt_badvaddr == $past(lk_vaddr))); // R10
   AST_FAULT_ASID: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_fault) |-> (flt_entryhi[ASID_W-1:0] == $past(lk_asid))); // R10

endmodule

// File: tb/sim_ptlb_pair_lookup.sv
module sim_ptlb_pair_lookup;
   localparam int CLK_PERIOD = 10;
   localparam int NE = 8;

   typedef struct {
      logic [31:0] vpn;
      logic [31:0] mask;
      logic [7:0]  asid;
      logic        g;
      logic [31:0] pfn0;
      logic [31:0] pfn1;
      logic [1:0]  v;
      logic [1:0]  d;
   } ent_t;

   typedef struct {
      logic [2:0]  code;
      logic [31:0] paddr;
      logic [1:0]  perm;
      logic        fault;
      logic [31:0] badv;
      logic [31:0] ctx;
      logic [31:0] ehi;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_idx = '0;
   logic [31:0] wr_vpn = '0, wr_mask = '0, wr_pfn_even = '0, wr_pfn_odd = '0;
   logic [7:0]  wr_asid = '0;
   logic        wr_global = 1'b0;
   logic [1:0]  wr_valid = '0, wr_dirty = '0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_vaddr = '0;
   logic [7:0]  lk_asid = '0;
   logic        lk_write = 1'b0;
   logic [31:0] cur_context = '0;
   logic        res_valid;
   logic [2:0]  res_code;
   logic [31:0] res_paddr;
   logic [1:0]  res_perm;
   logic        res_fault;
   logic [31:0] flt_badvaddr, flt_context, flt_entryhi;

   int   checks = 0;
   int   fails  = 0;
   bit   done   = 0;
   ent_t sh [NE];
   exp_t q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   ptlb_pair_lookup #(.NUM_ENTRIES(NE)) u0 (
      .clk, .rst_n, .wr_en, .wr_idx, .wr_vpn, .wr_mask, .wr_asid, .wr_global,
      .wr_pfn_even, .wr_pfn_odd, .wr_valid, .wr_dirty, .lk_valid, .lk_vaddr,
      .lk_asid, .lk_write, .cur_context, .res_valid, .res_code, .res_paddr,
      .res_perm, .res_fault, .flt_badvaddr, .flt_context, .flt_entryhi
   );

   function automatic exp_t model(logic [31:0] va, logic [7:0] asid, logic wr,
                                  logic [31:0] ctx, string tag);
      exp_t e;
      int   h = -1;
      logic odd = 1'b0;
      logic [31:0] em, offm = '0;
      e = '{code: 3'd0, paddr: '0, perm: '0, fault: 1'b0, badv: '0, ctx: '0, ehi: '0, tag: tag};
      for (int i = 0; i < NE; i++) begin
         em = sh[i].mask | 32'h0000_1FFF;
         if (h < 0 && (sh[i].g || sh[i].asid == asid) && ((va & ~em) == (sh[i].vpn & ~em))) begin
            h    = i;
            odd  = |(va & em & ~(em >> 1));
            offm = em >> 1;
         end
      end
      if (h < 0)                      e.code = 3'd2;
      else if (!sh[h].v[odd])         e.code = 3'd3;
      else if (wr && !sh[h].d[odd])   e.code = 3'd4;
      else begin
         e.code  = 3'd0;
         e.paddr = (odd ? sh[h].pfn1 : sh[h].pfn0) | (va & offm);
         e.perm  = {sh[h].d[odd], 1'b1};
      end
      if (e.code != 3'd0) begin
         e.fault = 1'b1;
         e.badv  = va;
         e.ctx   = (ctx & 32'hFF80_0000) | ((va >> 9) & 32'h007F_FFF0);
         e.ehi   = (va & 32'hFFFF_E000) | {24'h0, asid};
      end
      return e;
   endfunction

   // one cycle: optional entry load and optional lookup
   task automatic cyc(bit w, int idx, ent_t en, bit l, logic [31:0] va,
                      logic [7:0] asid, logic wr, logic [31:0] ctx, string tag);
      @(negedge clk);
      wr_en       = w;
      wr_idx      = 3'(idx);
      wr_vpn      = en.vpn;
      wr_mask     = en.mask;
      wr_asid     = en.asid;
      wr_global   = en.g;
      wr_pfn_even = en.pfn0;
      wr_pfn_odd  = en.pfn1;
      wr_valid    = en.v;
      wr_dirty    = en.d;
      lk_valid    = l;
      lk_vaddr    = va;
      lk_asid     = asid;
      lk_write    = wr;
      cur_context = ctx;
      if (l) q.push_back(model(va, asid, wr, ctx, tag));
      if (w) sh[idx] = en;
   endtask

   ent_t nil = '{vpn: '0, mask: '0, asid: '0, g: 1'b0, pfn0: '0, pfn1: '0, v: '0, d: '0};

   task automatic load(int idx, ent_t en);
      cyc(1, idx, en, 0, '0, '0, 0, '0, "");
   endtask

   task automatic look(logic [31:0] va, logic [7:0] asid, logic wr, string tag);
      cyc(0, 0, nil, 1, va, asid, wr, 32'hABCD_1234, tag);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc(0, 0, nil, 0, '0, '0, 0, '0, "");
   endtask

   // monitor: compare each result against the queued expectation
   always @(negedge clk) begin
      if (rst_n && res_valid && !done) begin
         checks++;
         if (q.size() == 0) begin
            fails++;
            $display("FAIL R2 unexpected result: actual code %0d, expected no result", res_code);
         end else begin
            exp_t e;
            e = q.pop_front();
            if (res_code !== e.code || res_paddr !== e.paddr || res_perm !== e.perm ||
                res_fault !== e.fault || flt_badvaddr !== e.badv ||
                flt_context !== e.ctx || flt_entryhi !== e.ehi) begin
               fails++;
               $display("FAIL %s actual code=%0d pa=%h perm=%b f=%b bv=%h ctx=%h ehi=%h expected code=%0d pa=%h perm=%b f=%b bv=%h ctx=%h ehi=%h",
                        e.tag, res_code, res_paddr, res_perm, res_fault, flt_badvaddr,
                        flt_context, flt_entryhi, e.code, e.paddr, e.perm, e.fault,
                        e.badv, e.ctx, e.ehi);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog expired: actual hung, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      ent_t e3, e4, e5, e6, e7, e1;
      for (int i = 0; i < NE; i++) sh[i] = nil;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (res_valid !== 1'b0 || res_code !== 3'd0 || res_fault !== 1'b0) begin
         fails++;
         $display("FAIL R1 reset outputs: actual valid=%b code=%0d, expected 0 0", res_valid, res_code);
      end

      // R1: cleared entries give INVALID on address 0, ASID 0
      look(32'h0000_0000, 8'h00, 0, "R1 reset lookup");

      e3 = '{vpn: 32'h0040_0000, mask: '0, asid: 8'h05, g: 1'b0,
             pfn0: 32'h1000_0000, pfn1: 32'h2000_0000, v: 2'b11, d: 2'b01};
      load(3, e3);
      look(32'h0040_0123, 8'h05, 0, "R6 even read match");
      look(32'h0040_1456, 8'h05, 0, "R4 odd read match");
      look(32'h0040_1456, 8'h05, 1, "R7 odd write dirty");
      look(32'h0040_0FFC, 8'h05, 1, "R6 even write match");
      look(32'h0040_0123, 8'h06, 0, "R3 asid mismatch");
      look(32'h7FFF_E004, 8'h05, 1, "R8 R10 nomatch fault regs");

      e4 = '{vpn: 32'h0080_0000, mask: '0, asid: 8'h09, g: 1'b1,
             pfn0: 32'h0A00_0000, pfn1: 32'h0B00_0000, v: 2'b01, d: 2'b00};
      load(4, e4);
      look(32'h0080_0ABC, 8'h02, 0, "R3 global match");
      look(32'h0080_1ABC, 8'h02, 0, "R5 odd invalid");
      look(32'h0080_0ABC, 8'h02, 1, "R7 global write dirty");

      e5 = '{vpn: 32'h0100_0000, mask: 32'h0001_E000, asid: 8'h05, g: 1'b0,
             pfn0: 32'h0C00_0000, pfn1: 32'h3000_0000, v: 2'b11, d: 2'b11};
      load(5, e5);
      look(32'h0101_2345, 8'h05, 1, "R4 large page odd");
      look(32'h0100_F00F, 8'h05, 0, "R4 large page even");
      look(32'h0102_0000, 8'h05, 0, "R3 large page outside");

      e6 = '{vpn: 32'h0200_0000, mask: '0, asid: 8'h00, g: 1'b1,
             pfn0: 32'h0600_0000, pfn1: 32'h0610_0000, v: 2'b11, d: 2'b11};
      e7 = e6;
      e7.pfn0 = 32'h0700_0000;
      load(7, e7);
      load(6, e6);
      look(32'h0200_0010, 8'h11, 0, "R9 lower index wins 6");
      e1 = e7;
      e1.pfn0 = 32'h0100_0000;
      e1.v    = 2'b10;
      load(1, e1);
      look(32'h0200_0010, 8'h11, 0, "R9 lower index wins 1");

      // R11: load and lookup in the same cycle see the old entry
      e3.v = 2'b00;
      cyc(1, 3, e3, 1, 32'h0040_0123, 8'h05, 0, 32'h0, "R11 same-cycle old contents");
      look(32'h0040_0123, 8'h05, 0, "R11 new contents invalid");

      // R2: back-to-back lookups
      look(32'h0101_0004, 8'h05, 0, "R2 back to back 1");
      look(32'h0080_0004, 8'h33, 0, "R2 back to back 2");
      look(32'h0555_0000, 8'h33, 0, "R2 back to back 3");
      idle(3);

      checks++;
      if (q.size() != 0) begin
         fails++;
         $display("FAIL R2 pending results: actual %0d, expected 0", q.size());
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule